// File: doc/BRIEF.md
# Dual Sixteen-Bit Counter with Shared Compare Bank

This peripheral holds two independent 16-bit counters and a bank of six 16-bit compare registers, all reached over a simple single-cycle 32-bit register bus. Each counter has a preload value register, a prescale register and a control register. The control register holds three things: a halt bit, a direction bit and a 3-bit end-of-count selector. With the selector a counter can stop when it reaches zero, stop when it reaches one of the six compare values, or wrap for ever. A counter that stops on a compare value latches the event into a six-bit event register. That register shares its index with the compare register that matched.

The bus has two windows, picked by a window-select input. The main window holds the counter and compare registers. The event window holds the event register, which is cleared by writing ones to it, and an enable register. The single level interrupt output is high whenever an event bit and its enable bit are both set.

A typical use is a one-shot deadline: software preloads a counter, sets compare register 0 to zero and starts the counter counting down with selector 1. A second counter runs free and counts up as a time base.

Top module: `dmt_timer`

## Requirements
- R1: After reset both counters read 0 and their control registers read 0x10 (halted, counting down, selector 0). Both prescale registers, all compare registers, the event register and the enable register read 0, and the interrupt output is low.
- R2: Main window (window select 0), with byte addresses and bits [1:0] ignored. Counter 0 has its value at 0x00, its prescale at 0x04 and its control at 0x08. Counter 1 has its value at 0x0C, its prescale at 0x10 and its control at 0x14. Compare register k is at 0x18+4k. Event window (window select 1): the event register is at 0x00 and the enable register at 0x04. Value, prescale and compare registers keep bits [15:0] of a write, control keeps bits [4:0] and enable keeps bits [5:0]. All other bits, and every unmapped address, read as 0.
- R3: While control bit 4 is 1 the counter value does not change except by a bus write.
- R4: Control bit 3 = 1 counts up and 0 counts down. With selector 7 the counter wraps modulo 2^16 in either direction and never halts.
- R5: A prescale value N makes a running counter step once every N+1 clocks. The first step comes N+1 clocks after the control or prescale write.
- R6: With selector s in 1..6, if the value after a step equals compare register s-1, the counter holds that value, sets control bit 4 and sets event bit s-1 on the same clock edge.
- R7: With selector 0, a counter that steps to zero holds at zero and sets control bit 4. It sets no event bit.
- R8: Writing the event register clears each bit written as 1 and leaves bits written as 0 alone. An event that arrives on the same edge as a clearing write stays set.
- R9: Event bits are set whether or not they are enabled. The interrupt output is high exactly when some event bit and its enable bit are both 1.
- R10: Writing a counter's value register loads that value on the next edge, even while the counter is running. Counting continues from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per clock |
| bus_win_i | input | 1 | Window select: 0 main, 1 event window |
| bus_addr_i | input | 6 | Byte address within the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a clearing write to the event register that lands on the same edge as the compare hit it would erase. The stimulus counts clocks from the control write that starts a short countdown. It then issues the acknowledge so that its write edge coincides with the step onto the compare value, and it checks afterwards that the event bit survived. Halt and wrap cases are reached by choosing preload values next to the compare value or next to the 16-bit boundary, together with prescale settings that make the step count exact.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam int NTMR       = 2;
    localparam int MATCH_N    = 6;
    localparam int REGS_PER_T = 3;
    localparam int MATCH_WORD = NTMR * REGS_PER_T;

    typedef struct packed {
        logic       halt;
        logic       up;
        logic [2:0] mode;
    } tmr_ctrl_t;

    localparam logic [2:0] MODE_TO_ZERO = 3'd0;
    localparam logic [2:0] MODE_FREE    = 3'd7;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_VAL,
        RS_DIV,
        RS_CTRL,
        RS_MATCH,
        RS_STS,
        RS_MSK
    } rsel_kind_e;

    typedef struct packed {
        rsel_kind_e kind;
        logic [2:0] idx;
    } rsel_t;

endpackage

// File: rtl/dmt_decode.sv
module dmt_decode
    import dmt_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              bus_wr_i,
    input  logic              bus_win_i,
    input  logic [WORD_W-1:0] word_i,
    output rsel_t             rsel_o,
    output logic [NTMR-1:0]   wr_val_o,
    output logic [NTMR-1:0]   wr_div_o,
    output logic [NTMR-1:0]   wr_ctrl_o,
    output logic [MATCH_N-1:0] wr_match_o,
    output logic              wr_sts_o,
    output logic              wr_msk_o
);

    always_comb begin
        rsel_o = '{kind: RS_NONE, idx: 3'd0};
        if (!bus_win_i) begin
            for (int t = 0; t < NTMR; t++) begin
                if (word_i == WORD_W'(REGS_PER_T * t)) begin
                    rsel_o = '{kind: RS_VAL, idx: 3'(t)};
                end
                if (word_i == WORD_W'(REGS_PER_T * t + 1)) begin
                    rsel_o = '{kind: RS_DIV, idx: 3'(t)};
                end
                if (word_i == WORD_W'(REGS_PER_T * t + 2)) begin
                    rsel_o = '{kind: RS_CTRL, idx: 3'(t)};
                end
            end
            for (int k = 0; k < MATCH_N; k++) begin
                if (word_i == WORD_W'(MATCH_WORD + k)) begin
                    rsel_o = '{kind: RS_MATCH, idx: 3'(k)};
                end
            end
        end else begin
            if (word_i == WORD_W'(0)) begin
                rsel_o = '{kind: RS_STS, idx: 3'd0};
            end
            if (word_i == WORD_W'(1)) begin
                rsel_o = '{kind: RS_MSK, idx: 3'd0};
            end
        end
    end

    always_comb begin
        wr_val_o   = '0;
        wr_div_o   = '0;
        wr_ctrl_o  = '0;
        wr_match_o = '0;
        for (int t = 0; t < NTMR; t++) begin
            wr_val_o[t]  = bus_wr_i && rsel_o.kind == RS_VAL  && rsel_o.idx == 3'(t);
            wr_div_o[t]  = bus_wr_i && rsel_o.kind == RS_DIV  && rsel_o.idx == 3'(t);
            wr_ctrl_o[t] = bus_wr_i && rsel_o.kind == RS_CTRL && rsel_o.idx == 3'(t);
        end
        for (int k = 0; k < MATCH_N; k++) begin
            wr_match_o[k] = bus_wr_i && rsel_o.kind == RS_MATCH && rsel_o.idx == 3'(k);
        end
        wr_sts_o = bus_wr_i && rsel_o.kind == RS_STS;
        wr_msk_o = bus_wr_i && rsel_o.kind == RS_MSK;
    end

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter
    import dmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_val_i,
    input  logic                           wr_div_i,
    input  logic                           wr_ctrl_i,
    input  logic [CNT_W-1:0]               wdata_i,
    input  logic [MATCH_N-1:0][CNT_W-1:0]  match_i,
    output logic [CNT_W-1:0]               value_o,
    output logic [CNT_W-1:0]               div_o,
    output tmr_ctrl_t                      ctrl_o,
    output logic [MATCH_N-1:0]             hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] value;
        logic [CNT_W-1:0] div;
        logic [CNT_W-1:0] presc;
        tmr_ctrl_t        ctrl;
    } cnt_st_t;

    localparam tmr_ctrl_t CTRL_RST = '{halt: 1'b1, up: 1'b0, mode: MODE_TO_ZERO};

    cnt_st_t          st_d, st_q;
    logic [CNT_W-1:0] step_d;

    always_comb begin
        st_d   = st_q;
        hit_o  = '0;
        step_d = st_q.ctrl.up ? st_q.value + CNT_W'(1) : st_q.value - CNT_W'(1);

        if (!st_q.ctrl.halt) begin
            if (st_q.presc == st_q.div) begin
                st_d.presc = '0;
                st_d.value = step_d;
                if (st_q.ctrl.mode == MODE_TO_ZERO) begin
                    if (step_d == '0) begin
                        st_d.ctrl.halt = 1'b1;
                    end
                end else if (st_q.ctrl.mode != MODE_FREE) begin
                    for (int k = 0; k < MATCH_N; k++) begin
                        if (st_q.ctrl.mode == 3'(k + 1) && step_d == match_i[k]) begin
                            st_d.ctrl.halt = 1'b1;
                            hit_o[k]       = 1'b1;
                        end
                    end
                end
            end else begin
                st_d.presc = st_q.presc + CNT_W'(1);
            end
        end

        if (wr_val_i) begin
            st_d.value = wdata_i;
        end
        if (wr_div_i) begin
            st_d.div   = wdata_i;
            st_d.presc = '0;
        end
        if (wr_ctrl_i) begin
            st_d.ctrl  = tmr_ctrl_t'(wdata_i[4:0]);
            st_d.presc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.value <= '0;
            st_q.div   <= '0;
            st_q.presc <= '0;
            st_q.ctrl  <= CTRL_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.value;
    assign div_o   = st_q.div;
    assign ctrl_o  = st_q.ctrl;

    // R3: a halted counter keeps its value unless the bus reloads it
    p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.halt && !wr_val_i) |=> (st_q.value == $past(st_q.value)));

    // R5: the prescale phase never runs past the programmed divider
    p_presc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.presc <= st_q.div);

    // R6: a compare hit halts the counter on the same edge
    p_hit_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hit_o) && !wr_ctrl_i) |=> st_q.ctrl.halt);

    // R6: at most one compare register is reported per step
    p_hit_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_o));

    // R7: count-to-zero never raises an event
    p_zero_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.mode == MODE_TO_ZERO) |-> (hit_o == '0));

endmodule

// File: rtl/dmt_irq.sv
module dmt_irq
    import dmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MATCH_N-1:0] hit_i,
    input  logic               wr_sts_i,
    input  logic               wr_msk_i,
    input  logic [MATCH_N-1:0] wdata_i,
    output logic [MATCH_N-1:0] status_o,
    output logic [MATCH_N-1:0] mask_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [MATCH_N-1:0] sts;
        logic [MATCH_N-1:0] msk;
    } irq_st_t;

    irq_st_t            st_d, st_q;
    logic [MATCH_N-1:0] clr_d;

    always_comb begin
        st_d    = st_q;
        clr_d   = wr_sts_i ? wdata_i : '0;
        st_d.sts = (st_q.sts & ~clr_d) | hit_i;
        if (wr_msk_i) begin
            st_d.msk = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.sts;
    assign mask_o   = st_q.msk;
    assign irq_o    = |(st_q.sts & st_q.msk);

    // R8: every arriving event is recorded, even against a clearing write
    p_hit_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((st_q.sts & $past(hit_i)) == $past(hit_i)));

    // R8: bits written as one are gone after the write when no event races it
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts_i && hit_i == '0) |=> ((st_q.sts & $past(wdata_i)) == '0));

    // R9: the interrupt line needs a recorded event behind it
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (|st_q.sts));

endmodule

// File: rtl/dmt_timer.sv
module dmt_timer
    import dmt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_win_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);

    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [MATCH_N-1:0][CNT_W-1:0] match;
    } top_st_t;

    top_st_t                        st_d, st_q;
    rsel_t                          rsel;
    logic [NTMR-1:0]                wr_val, wr_div, wr_ctrl;
    logic [MATCH_N-1:0]             wr_match;
    logic                           wr_sts, wr_msk;
    logic [NTMR-1:0][CNT_W-1:0]     tmr_val, tmr_div;
    tmr_ctrl_t [NTMR-1:0]           tmr_ctrl;
    logic [NTMR-1:0][MATCH_N-1:0]   tmr_hit;
    logic [MATCH_N-1:0]             hit_any;
    logic [MATCH_N-1:0]             status, mask;
    logic                           unused_bits;

    assign unused_bits = ^{bus_wdata_i[31:CNT_W], bus_addr_i[1:0]};

    dmt_decode #(.WORD_W(WORD_W)) u_decode (
        .bus_wr_i   (bus_wr_i),
        .bus_win_i  (bus_win_i),
        .word_i     (bus_addr_i[ADDR_W-1:2]),
        .rsel_o     (rsel),
        .wr_val_o   (wr_val),
        .wr_div_o   (wr_div),
        .wr_ctrl_o  (wr_ctrl),
        .wr_match_o (wr_match),
        .wr_sts_o   (wr_sts),
        .wr_msk_o   (wr_msk)
    );

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        dmt_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_val_i  (wr_val[t]),
            .wr_div_i  (wr_div[t]),
            .wr_ctrl_i (wr_ctrl[t]),
            .wdata_i   (bus_wdata_i[CNT_W-1:0]),
            .match_i   (st_q.match),
            .value_o   (tmr_val[t]),
            .div_o     (tmr_div[t]),
            .ctrl_o    (tmr_ctrl[t]),
            .hit_o     (tmr_hit[t])
        );
    end

    always_comb begin
        hit_any = '0;
        for (int t = 0; t < NTMR; t++) begin
            hit_any = hit_any | tmr_hit[t];
        end
    end

    dmt_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_i    (hit_any),
        .wr_sts_i (wr_sts),
        .wr_msk_i (wr_msk),
        .wdata_i  (bus_wdata_i[MATCH_N-1:0]),
        .status_o (status),
        .mask_o   (mask),
        .irq_o    (irq_o)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < MATCH_N; k++) begin
            if (wr_match[k]) begin
                st_d.match[k] = bus_wdata_i[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (rsel.kind)
            RS_VAL, RS_DIV, RS_CTRL: begin
                for (int t = 0; t < NTMR; t++) begin
                    if (rsel.idx == 3'(t)) begin
                        if (rsel.kind == RS_VAL)  bus_rdata_o = 32'(tmr_val[t]);
                        if (rsel.kind == RS_DIV)  bus_rdata_o = 32'(tmr_div[t]);
                        if (rsel.kind == RS_CTRL) bus_rdata_o = 32'(tmr_ctrl[t]);
                    end
                end
            end
            RS_MATCH: begin
                for (int k = 0; k < MATCH_N; k++) begin
                    if (rsel.idx == 3'(k)) bus_rdata_o = 32'(st_q.match[k]);
                end
            end
            RS_STS:  bus_rdata_o = 32'(status);
            RS_MSK:  bus_rdata_o = 32'(mask);
            default: bus_rdata_o = '0;
        endcase
    end

    // R2: compare registers only change under a bus write to them
    p_match_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_match == '0) |=> (st_q.match == $past(st_q.match)));

    // R9: no interrupt without an enabled event bit
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);

endmodule

// File: tb/dmt_timer_test.sv
module dmt_timer_test;

    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_win = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] rv;

    always #(CLK_NS/2) clk = ~clk;

    dmt_timer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_win_i   (bus_win),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic        tmr;
        logic [15:0] start;
        logic [15:0] div;
        logic [7:0]  ctrl;
        logic [2:0]  midx;
        logic [15:0] mval;
        logic [7:0]  waitc;
        logic [15:0] exp_val;
        logic [5:0]  exp_sts;
        logic        exp_halt;
    } vec_t;

    // tmr start div ctrl midx mval wait | value status halted
    localparam vec_t VECS [10] = '{
        '{1'b0, 16'd10,    16'd0, 8'h01, 3'd0, 16'd0,  8'd4,  16'd6,     6'h00, 1'b0},
        '{1'b0, 16'd10,    16'd0, 8'h01, 3'd0, 16'd0,  8'd10, 16'd0,     6'h01, 1'b1},
        '{1'b0, 16'd10,    16'd0, 8'h01, 3'd0, 16'd0,  8'd15, 16'd0,     6'h01, 1'b1},
        '{1'b1, 16'd5,     16'd1, 8'h0B, 3'd2, 16'd20, 8'd10, 16'd10,    6'h00, 1'b0},
        '{1'b1, 16'd5,     16'd1, 8'h0B, 3'd2, 16'd20, 8'd30, 16'd20,    6'h04, 1'b1},
        '{1'b0, 16'hFFFE,  16'd0, 8'h0F, 3'd0, 16'd0,  8'd5,  16'd3,     6'h00, 1'b0},
        '{1'b1, 16'd3,     16'd0, 8'h00, 3'd0, 16'd0,  8'd8,  16'd0,     6'h00, 1'b1},
        '{1'b0, 16'd100,   16'd2, 8'h06, 3'd5, 16'd90, 8'd30, 16'd90,    6'h20, 1'b1},
        '{1'b1, 16'd7,     16'd0, 8'h18, 3'd0, 16'd0,  8'd10, 16'd7,     6'h00, 1'b1},
        '{1'b0, 16'd1,     16'd0, 8'h07, 3'd0, 16'd0,  8'd3,  16'hFFFE,  6'h00, 1'b0}
    };

    task automatic wr(input logic win, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_win   = win;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic win, input logic [5:0] a, output logic [31:0] d);
        bus_win  = win;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic quiesce();
        wr(1'b0, 6'h08, 32'h10);
        wr(1'b0, 6'h14, 32'h10);
        wr(1'b1, 6'h00, 32'h3F);
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of every mapped register and of the line
        for (int w = 0; w < 12; w++) begin
            rd(1'b0, 6'(4 * w), rv);
            check("R1 reset main", rv, (w == 2 || w == 5) ? 32'h10 : 32'h0);
        end
        rd(1'b1, 6'h00, rv); check("R1 reset status", rv, 32'h0);
        rd(1'b1, 6'h04, rv); check("R1 reset enable", rv, 32'h0);
        check("R1 reset irq", {31'd0, irq}, 32'h0);

        // R2: unmapped addresses and field widths
        rd(1'b0, 6'h30, rv); check("R2 unmapped main", rv, 32'h0);
        rd(1'b1, 6'h08, rv); check("R2 unmapped event window", rv, 32'h0);
        wr(1'b0, 6'h10, 32'h1234ABCD);
        rd(1'b0, 6'h10, rv); check("R2 prescale width", rv, 32'h0000ABCD);
        wr(1'b0, 6'h14, 32'hFFFFFFFF);
        rd(1'b0, 6'h14, rv); check("R2 control width", rv, 32'h0000001F);
        wr(1'b0, 6'h24, 32'hFFFF5A5A);
        rd(1'b0, 6'h24, rv); check("R2 compare 3 width", rv, 32'h00005A5A);
        wr(1'b1, 6'h04, 32'hFFFFFFFF);
        rd(1'b1, 6'h04, rv); check("R2 enable width", rv, 32'h0000003F);

        // R3 R4 R5 R6 R7: table of counting scenarios
        foreach (VECS[i]) begin
            logic [5:0] base;
            base = VECS[i].tmr ? 6'h0C : 6'h00;
            quiesce();
            wr(1'b1, 6'h04, 32'h3F);
            wr(1'b0, 6'h18 + 6'(4 * VECS[i].midx), 32'(VECS[i].mval));
            wr(1'b0, base, 32'(VECS[i].start));
            wr(1'b0, base + 6'h04, 32'(VECS[i].div));
            wr(1'b0, base + 6'h08, 32'(VECS[i].ctrl));
            repeat (VECS[i].waitc) @(negedge clk);
            rd(1'b0, base, rv);
            check("R4 R5 vector value", rv, 32'(VECS[i].exp_val));
            rd(1'b0, base + 6'h08, rv);
            check("R3 R6 R7 vector halt bit", {31'd0, rv[4]}, {31'd0, VECS[i].exp_halt});
            rd(1'b1, 6'h00, rv);
            check("R6 R7 vector status", rv, 32'(VECS[i].exp_sts));
            check("R9 vector irq", {31'd0, irq}, {31'd0, VECS[i].exp_sts != 6'h0});
        end

        // R9: event recorded while disabled, line follows enable
        quiesce();
        wr(1'b1, 6'h04, 32'h00);
        wr(1'b0, 6'h18, 32'h0);
        wr(1'b0, 6'h00, 32'd2);
        wr(1'b0, 6'h04, 32'd0);
        wr(1'b0, 6'h08, 32'h01);
        repeat (3) @(negedge clk);
        rd(1'b1, 6'h00, rv); check("R9 status while disabled", rv, 32'h01);
        check("R9 irq while disabled", {31'd0, irq}, 32'h0);
        wr(1'b1, 6'h04, 32'h01);
        #1; check("R9 irq after enable", {31'd0, irq}, 32'h1);

        // R8: writing zeros keeps the bit, writing one clears it
        wr(1'b1, 6'h00, 32'h3E);
        rd(1'b1, 6'h00, rv); check("R8 zero write keeps bit", rv, 32'h01);
        wr(1'b1, 6'h00, 32'h01);
        rd(1'b1, 6'h00, rv); check("R8 one write clears bit", rv, 32'h00);
        check("R8 irq after clear", {31'd0, irq}, 32'h0);

        // R8: acknowledge lands on the same edge as the hit
        wr(1'b0, 6'h00, 32'd3);
        wr(1'b0, 6'h08, 32'h01);
        repeat (1) @(negedge clk);
        wr(1'b1, 6'h00, 32'h01);
        rd(1'b1, 6'h00, rv); check("R8 set wins over clear", rv, 32'h01);
        rd(1'b0, 6'h00, rv); check("R8 collision value", rv, 32'h0);

        // R10: reload a running free counter
        quiesce();
        wr(1'b0, 6'h0C, 32'd0);
        wr(1'b0, 6'h10, 32'd0);
        wr(1'b0, 6'h14, 32'h0F);
        repeat (5) @(negedge clk);
        wr(1'b0, 6'h0C, 32'h100);
        rd(1'b0, 6'h0C, rv); check("R10 preload while running", rv, 32'h100);
        repeat (4) @(negedge clk);
        rd(1'b0, 6'h0C, rv); check("R10 counts on from preload", rv, 32'h104);

        // R3: halting freezes a running counter
        wr(1'b0, 6'h14, 32'h1F);
        rd(1'b0, 6'h0C, rv);
        repeat (6) @(negedge clk);
        begin
            logic [31:0] rv2;
            rd(1'b0, 6'h0C, rv2);
            check("R3 halted value frozen", rv2, rv);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule